// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block is an eight-stage serial-in, parallel-out shift register. The bit shifted into the first stage is the logical AND of two serial inputs. Either input can therefore hold the register's feed at zero while the other carries the data stream. All stages move one place on each rising clock edge. The last stage is also brought out on its own pin, so a second register can be cascaded by wiring it to that register's serial input.

An asynchronous active-low clear drives every stage to zero at once, without waiting for a clock edge. It keeps them at zero for as long as it is held, so the outputs are defined from power-up when clear starts low. The parallel outputs come straight from the stages. There is no holding latch, so they change on every shifting edge.

Top module: `sipo_gated`

## Requirements
- R1: Driving `clearN` low forces all of `parOut` and `cascadeOut` to zero at once, without a clock edge.
- R2: While `clearN` is low, rising clock edges do not shift: the outputs stay zero whatever `serA` and `serB` are.
- R3: On each rising clock edge with `clearN` high, `parOut[0]` (the first stage) takes the value `serA AND serB`.
- R4: If `serA` or `serB` is low at a rising edge, a zero enters `parOut[0]`, whatever the other input is.
- R5: On each rising edge with `clearN` high, `parOut[i]` takes the value held by `parOut[i-1]` before the edge, for i = 1 to 7. The old value of `parOut[7]` is dropped.
- R6: After eight edges, the first bit shifted in sits in `parOut[7]` and the eighth bit sits in `parOut[0]`.
- R7: `cascadeOut` always equals `parOut[7]`, the last stage.
- R8: When there is no rising clock edge, the contents stay unchanged however `serA` and `serB` toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages update on its rising edge |
| clearN | input | 1 | Asynchronous clear, active low |
| serA | input | 1 | Serial input, ANDed with serB |
| serB | input | 1 | Serial input, ANDed with serA |
| parOut | output | 8 | Parallel stage outputs; bit 0 is the first stage, bit 7 the last |
| cascadeOut | output | 1 | Copy of the last stage for cascading |

## Verification
A data byte is first shifted in with both inputs high, then with one input tied high and the other carrying the data, and then the other way round. These runs separate a correct AND from a design that uses only one input, and from a design with a reversed stage order. Runs with one input held low and the other toggling show that the gate blocks the feed. A run of all ones followed by zeros shows that the old last-stage value is dropped and not recirculated. Clock edges under clear, a clear asserted between edges, and input toggling with the clock stopped tell apart clear priority, asynchronous clearing and state retention.

// File: rtl/sipo_gated_pkg.sv
package sipo_gated_pkg;
  typedef struct packed {
    logic feedOne;   // both serial inputs high: shift a one in
    logic feedZero;  // gate closed: shift a zero in
  } sipoStrobe_t;
endpackage

// File: rtl/sipo_gated_ctrl.sv
module sipo_gated_ctrl
  import sipo_gated_pkg::*;
(
  input  logic        serA,
  input  logic        serB,
  output sipoStrobe_t strobe
);
  logic gateOpen;

  always_comb begin
    gateOpen        = serA & serB;
    strobe.feedOne  = gateOpen;
    strobe.feedZero = ~gateOpen;
  end
endmodule

// File: rtl/sipo_gated_dp.sv
module sipo_gated_dp
  import sipo_gated_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              clearN,
  input  sipoStrobe_t       strobe,
  output logic [STAGES-1:0] stageQ
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stageD;

  assign stageD[0] = strobe.feedOne & ~strobe.feedZero;

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_link
      assign stageD[g] = stageQ[g-1];
    end
    for (g = 0; g <= LAST; g++) begin : g_stage
      always_ff @(posedge clk or negedge clearN) begin
        if (!clearN) stageQ[g] <= 1'b0;
        else         stageQ[g] <= stageD[g];
      end
    end
  endgenerate
endmodule

// File: rtl/sipo_gated.sv
module sipo_gated
  import sipo_gated_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              clearN,
  input  logic              serA,
  input  logic              serB,
  output logic [STAGES-1:0] parOut,
  output logic              cascadeOut
);
  sipoStrobe_t strobe;
  logic [STAGES-1:0] stageQ;

  sipo_gated_ctrl uCtrl (
    .serA   (serA),
    .serB   (serB),
    .strobe (strobe)
  );

  sipo_gated_dp #(.STAGES(STAGES)) uDp (
    .clk    (clk),
    .clearN (clearN),
    .strobe (strobe),
    .stageQ (stageQ)
  );

  assign parOut     = stageQ;
  assign cascadeOut = stageQ[STAGES-1];
endmodule

// File: rtl/sipo_gated_chk.sv
module sipo_gated_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              clearN,
  input logic              serA,
  input logic              serB,
  input logic [STAGES-1:0] parOut,
  input logic              cascadeOut
);
  // R2: under clear, sampled outputs are all zero at every edge
  p_clear_holds_zero_r2: assert property (@(posedge clk)
    !clearN |-> (parOut == '0));

  // R3: first stage captures the AND of the serial inputs
  p_first_stage_and_r3: assert property (@(posedge clk) disable iff (!clearN)
    1'b1 |=> (parOut[0] == $past(serA & serB)));

  // R4: a low input feeds a zero
  p_gate_blocks_r4: assert property (@(posedge clk) disable iff (!clearN)
    !(serA && serB) |=> !parOut[0]);

  // R5: every later stage takes its neighbour's prior value
  p_chain_moves_r5: assert property (@(posedge clk) disable iff (!clearN)
    1'b1 |=> (parOut[STAGES-1:1] == $past(parOut[STAGES-2:0])));

  // R7: cascade output tracks the last stage
  p_cascade_last_r7: assert property (@(posedge clk) disable iff (!clearN)
    cascadeOut == parOut[STAGES-1]);
endmodule

bind sipo_gated sipo_gated_chk #(.STAGES(STAGES)) uChk (
  .clk        (clk),
  .clearN     (clearN),
  .serA       (serA),
  .serB       (serB),
  .parOut     (parOut),
  .cascadeOut (cascadeOut)
);

// File: tb/sim_sipo_gated.sv
module sim_sipo_gated;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       clk = 1'b0;
  logic       clearN = 1'b0;
  logic       serA = 1'b0;
  logic       serB = 1'b0;
  logic [7:0] parOut;
  logic       cascadeOut;

  logic [7:0] model = 8'h00;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sipo_gated u0 (
    .clk        (clk),
    .clearN     (clearN),
    .serA       (serA),
    .serB       (serB),
    .parOut     (parOut),
    .cascadeOut (cascadeOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock cycle: inputs set while clk low, sampled mid high phase
  task automatic step(input logic a, input logic b);
    serA = a;
    serB = b;
    #2;
    clk = 1'b1;
    if (clearN) model = {model[6:0], a & b};
    #2;
    check("R7 cascade", {7'b0, cascadeOut}, {7'b0, model[7]});
    #(HALF - 2);
    clk = 1'b0;
    #(HALF - 2);
  endtask

  task automatic t_reset();
    clearN = 1'b0;
    #3;
    check("R1 reset state", parOut, 8'h00);
    step(1, 1);
    check("R2 edge under clear", parOut, 8'h00);
    step(1, 1);
    check("R2 second edge under clear", parOut, 8'h00);
    clearN = 1'b1;
    #1;
    check("R2 release without edge", parOut, 8'h00);
  endtask

  task automatic t_byte_both(input logic [7:0] data);
    for (int i = 7; i >= 0; i--) step(data[i], data[i]);
    check("R6 byte via both inputs", parOut, data);
  endtask

  task automatic t_byte_a_data(input logic [7:0] data);
    for (int i = 7; i >= 0; i--) begin
      step(data[i], 1'b1);
      check("R3 first stage A data", {7'b0, parOut[0]}, {7'b0, data[i]});
    end
    check("R6 byte via A", parOut, data);
  endtask

  task automatic t_byte_b_data(input logic [7:0] data);
    for (int i = 7; i >= 0; i--) step(1'b1, data[i]);
    check("R6 byte via B", parOut, data);
    check("R5 chain matches model", parOut, model);
  endtask

  task automatic t_gate_low();
    for (int i = 0; i < 4; i++) begin
      step(1'b0, i[0]);
      check("R4 A low", {7'b0, parOut[0]}, 8'h00);
      step(i[0], 1'b0);
      check("R4 B low", {7'b0, parOut[0]}, 8'h00);
    end
    check("R4 pattern after gating", parOut, model);
  endtask

  task automatic t_discard();
    for (int i = 0; i < 8; i++) step(1, 1);
    check("R5 all ones", parOut, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      step(0, 1);
      check("R5 ones leave one by one", parOut, 8'hFF << (i + 1));
    end
    step(1, 1);
    check("R5 old last stage dropped", parOut, 8'h01);
  endtask

  task automatic t_hold();
    logic [7:0] snap;
    for (int i = 7; i >= 0; i--) step(8'hA5 >> i, 1'b1);
    snap = parOut;
    check("R6 hold setup", snap, 8'hA5);
    for (int i = 0; i < 12; i++) begin
      serA = i[0];
      serB = i[1];
      #3;
    end
    check("R8 no edge keeps contents", parOut, snap);
  endtask

  task automatic t_async_clear();
    for (int i = 0; i < 8; i++) step(1, 1);
    check("R1 setup ones", parOut, 8'hFF);
    #1;
    clearN = 1'b0;
    #1;
    check("R1 async clear mid cycle", parOut, 8'h00);
    check("R1 cascade cleared", {7'b0, cascadeOut}, 8'h00);
    model = 8'h00;
    step(1, 1);
    check("R2 edge ignored under clear", parOut, 8'h00);
    clearN = 1'b1;
    #1;
    step(1, 1);
    check("R3 shift after clear release", parOut, 8'h01);
  endtask

  initial begin
    t_reset();
    t_byte_both(8'hB4);
    t_byte_a_data(8'h5C);
    t_byte_b_data(8'h39);
    t_gate_low();
    t_discard();
    t_hold();
    t_async_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule